// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block sits beside a DRAM controller's ECC checker and records the errors that the checker reports. Each cycle the checker may raise a correctable-error pulse, an uncorrectable-error pulse, or both. The checker presents one shared set of error details with the pulses: the physical address, an 8-bit syndrome and a one-bit channel identifier. The block keeps two sticky flags in a 16-bit status word. It also keeps one set of captured details: the failing address at 4 KiB page resolution, the syndrome, and the channel.

Software reaches the bank through a plain register port. The port has a write strobe, a 3-bit register select, 32-bit write data and combinational read data. The flags are write-one-to-clear. A command register holds one interrupt enable for each error type. The `irq` output stays high while any enabled flag is set.

Capture priority works as follows. An uncorrectable error replaces the details held for a pending correctable error. A correctable error never replaces the details of a pending uncorrectable error.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low. The registers are the status word, the captured address, the syndrome, the channel byte and the command register.
- R2: A correctable pulse with no flag pending does two things. It sets status bit 0 (select 0), and it captures the address, the syndrome (select 2) and the channel into bit 0 of the channel byte (select 3). Each update is visible one cycle later.
- R3: An uncorrectable pulse with no uncorrectable flag pending sets status bit 7 and captures the address, syndrome and channel, even when a correctable error is pending.
- R4: A correctable pulse while an uncorrectable error is pending sets status bit 0 and leaves the captured fields unchanged.
- R5: A correctable pulse while a correctable error is already pending leaves the status word and the captured fields unchanged.
- R6: An uncorrectable pulse while an uncorrectable error is pending leaves the status word and the captured fields unchanged.
- R7: Writing to the status word (select 0) has the following effects:
  - A one in bit 0 clears the correctable flag.
  - A one in bit 7 clears the uncorrectable flag.
  - Writing 0x0081 clears both flags.
  - A zero in either bit leaves that flag as it was.
  - Bits 15:8 and 6:1 always read zero.
- R8: When a clearing write and a new error of the same type land in the same cycle, the flag stays set and the new error's fields are captured.
- R9: Simultaneous correctable and uncorrectable pulses set both flags and capture the presented fields.
- R10: The captured address register (select 1) returns the failing address with bits 11:0 forced to zero.
- R11: The command register (select 4) works as follows:
  - Bit 0 enables the correctable flag onto `irq`, and bit 7 enables the uncorrectable flag.
  - The command register reads back its two enable bits.
  - `irq` is the OR of the flags gated by these enables.
- R12: Writes to the captured address, syndrome and channel selects have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_pulse | input | 1 | Correctable error reported this cycle |
| ue_pulse | input | 1 | Uncorrectable error reported this cycle |
| err_addr | input | 32 | Physical address of the reported error |
| err_syn | input | 8 | ECC syndrome of the reported error |
| err_chan | input | 1 | Channel the error came from |
| reg_sel | input | 3 | Register select for reads and writes |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | High while any enabled error flag is set |

## Verification
Error pulses are driven into four states of the flags:
- With nothing pending, to show fresh capture.
- Behind a pending error of the same type, to show the held details are kept.
- Behind a pending error of the other type, to tell the uncorrectable-overwrites rule apart from the correctable-keeps rule.
- With both pulses together.

Status writes use masks with one bit set, two bits set and no target bits set, so that each flag's clear can be told apart from the other's. One of these writes coincides with a new error, to show that the error wins. Addresses with nonzero low bits show the page truncation. Each enable is toggled on its own while only one flag is pending, which ties each enable to its own flag.

// File: rtl/ecc_log_pkg.sv
// Package: register selects and bit positions shared by the capture bank.
package ecc_log_pkg;
    localparam int SEL_W  = 3;
    localparam int STAT_W = 16;
    localparam int CE_BIT = 0;
    localparam int UE_BIT = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT = 3'd0,
        SEL_ADDR = 3'd1,
        SEL_SYND = 3'd2,
        SEL_CHAN = 3'd3,
        SEL_CMD  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/ecc_flag_ctl.sv
// Module: ecc_flag_ctl
// Holds the two sticky error flags and decides when the detail registers
// load. Assumes clear requests are already decoded from a status write.
// A flag that is being cleared in this cycle counts as not pending.
module ecc_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_pulse,
    input  logic ue_pulse,
    input  logic clr_ce,
    input  logic clr_ue,
    output logic ce_flag,
    output logic ue_flag,
    output logic cap_en
);
    logic ce_hold;
    logic ue_hold;

    // Flags that survive this cycle's clear request
    always_comb begin
        ce_hold = ce_flag & ~clr_ce;
        ue_hold = ue_flag & ~clr_ue;
    end

    // Load details for a fresh UE, or for a CE when nothing else is held
    always_comb begin
        cap_en = (ue_pulse & ~ue_hold) |
                 (ce_pulse & ~ue_pulse & ~ce_hold & ~ue_hold);
    end

    // Sticky flags: a new event beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_flag <= 1'b0;
            ue_flag <= 1'b0;
        end else begin
            ce_flag <= ce_pulse | ce_hold;
            ue_flag <= ue_pulse | ue_hold;
        end
    end
endmodule

// File: rtl/ecc_capture_regs.sv
// Module: ecc_capture_regs
// Stores the page number, syndrome and channel of the logged error.
// Assumes cap_en is a single-cycle load strobe from the flag logic.
module ecc_capture_regs #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SYN_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en,
    input  logic [ADDR_W-1:0]            err_addr,
    input  logic [SYN_W-1:0]             err_syn,
    input  logic                         err_chan,
    output logic [ADDR_W-PAGE_SHIFT-1:0] pg_q,
    output logic [SYN_W-1:0]             syn_q,
    output logic                         chan_q
);
    // Load the detail fields on a capture strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q   <= '0;
            syn_q  <= '0;
            chan_q <= 1'b0;
        end else if (cap_en) begin
            pg_q   <= err_addr[ADDR_W-1:PAGE_SHIFT];
            syn_q  <= err_syn;
            chan_q <= err_chan;
        end
    end
endmodule

// File: rtl/ecc_csr_port.sv
// Module: ecc_csr_port
// Decodes register writes into flag clears and enable updates, and builds
// read data. Assumes DATA_W >= ADDR_W and DATA_W >= STAT_W.
module ecc_csr_port
    import ecc_log_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SYN_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SEL_W-1:0]             reg_sel,
    input  logic                         reg_wen,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic                         ce_flag,
    input  logic                         ue_flag,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] pg_q,
    input  logic [SYN_W-1:0]             syn_q,
    input  logic                         chan_q,
    output logic                         clr_ce,
    output logic                         clr_ue,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         irq
);
    logic              en_ce;
    logic              en_ue;
    logic              stat_wr;
    logic              cmd_wr;
    logic [STAT_W-1:0] stat_word;
    logic [ADDR_W-1:0] addr_word;

    // Write decode for the status and command selects
    always_comb begin
        stat_wr = reg_wen && (reg_sel == SEL_STAT);
        cmd_wr  = reg_wen && (reg_sel == SEL_CMD);
        clr_ce  = stat_wr && reg_wdata[CE_BIT];
        clr_ue  = stat_wr && reg_wdata[UE_BIT];
    end

    // Interrupt enable bits in the command register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_ce <= 1'b0;
            en_ue <= 1'b0;
        end else if (cmd_wr) begin
            en_ce <= reg_wdata[CE_BIT];
            en_ue <= reg_wdata[UE_BIT];
        end
    end

    // Pending output: flags gated by their enables
    always_comb begin
        irq = (ce_flag & en_ce) | (ue_flag & en_ue);
    end

    // Assemble the status word and the page-aligned address
    always_comb begin
        stat_word         = '0;
        stat_word[CE_BIT] = ce_flag;
        stat_word[UE_BIT] = ue_flag;
        addr_word         = {pg_q, {PAGE_SHIFT{1'b0}}};
    end

    // Read multiplexer, zero for unused selects
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_STAT: reg_rdata = DATA_W'(stat_word);
            SEL_ADDR: reg_rdata = DATA_W'(addr_word);
            SEL_SYND: reg_rdata = DATA_W'(syn_q);
            SEL_CHAN: reg_rdata = DATA_W'(chan_q);
            SEL_CMD: begin
                reg_rdata[CE_BIT] = en_ce;
                reg_rdata[UE_BIT] = en_ue;
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log.sv
// Module: ecc_err_log
// Top of the ECC error capture bank: flag control, detail capture and the
// register port. Assumes pulses and details are synchronous to clk.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SYN_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              err_chan,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic            ce_flag;
    logic            ue_flag;
    logic            cap_en;
    logic            clr_ce;
    logic            clr_ue;
    logic [PG_W-1:0] pg_q;
    logic [SYN_W-1:0] syn_q;
    logic            chan_q;

    ecc_flag_ctl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_pulse (ce_pulse),
        .ue_pulse (ue_pulse),
        .clr_ce   (clr_ce),
        .clr_ue   (clr_ue),
        .ce_flag  (ce_flag),
        .ue_flag  (ue_flag),
        .cap_en   (cap_en)
    );

    ecc_capture_regs #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .SYN_W      (SYN_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .err_addr (err_addr),
        .err_syn  (err_syn),
        .err_chan (err_chan),
        .pg_q     (pg_q),
        .syn_q    (syn_q),
        .chan_q   (chan_q)
    );

    ecc_csr_port #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .SYN_W      (SYN_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .ce_flag   (ce_flag),
        .ue_flag   (ue_flag),
        .pg_q      (pg_q),
        .syn_q     (syn_q),
        .chan_q    (chan_q),
        .clr_ce    (clr_ce),
        .clr_ue    (clr_ue),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/ecc_err_log_chk.sv
// Module: ecc_err_log_chk
// Temporal checks on the capture bank, attached to every ecc_err_log.
module ecc_err_log_chk
    import ecc_log_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SYN_W      = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ce_pulse,
    input logic                         ue_pulse,
    input logic [SYN_W-1:0]             err_syn,
    input logic [SEL_W-1:0]             reg_sel,
    input logic                         reg_wen,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic                         ce_flag,
    input logic                         ue_flag,
    input logic [ADDR_W-PAGE_SHIFT-1:0] pg_q,
    input logic [SYN_W-1:0]             syn_q,
    input logic                         chan_q,
    input logic                         irq
);
    logic ue_clr_req;
    logic ce_clr_req;
    assign ue_clr_req = reg_wen && (reg_sel == SEL_STAT) && reg_wdata[UE_BIT];
    assign ce_clr_req = reg_wen && (reg_sel == SEL_STAT) && reg_wdata[CE_BIT];

    // R2
    ce_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |=> ce_flag);

    // R3
    ue_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |=> ue_flag);

    // R3
    ue_captures_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_pulse && !ue_flag) |=> (syn_q == $past(err_syn)));

    // R4
    ce_keeps_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !ue_clr_req && ce_pulse && !ue_pulse)
        |=> ($stable(pg_q) && $stable(syn_q) && $stable(chan_q)));

    // R7
    ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_clr_req && !ce_pulse) |=> !ce_flag);

    // R11
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_flag && !ue_flag) |-> !irq);
endmodule

bind ecc_err_log ecc_err_log_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SYN_W      (SYN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .err_syn   (err_syn),
    .reg_sel   (reg_sel),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .ce_flag   (ce_flag),
    .ue_flag   (ue_flag),
    .pg_q      (pg_q),
    .syn_q     (syn_q),
    .chan_q    (chan_q),
    .irq       (irq)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_pulse = 1'b0;
    logic        ue_pulse = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  err_syn = '0;
    logic        err_chan = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ecc_err_log dut (
        .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
        .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #2 val = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(sel, v);
        chk(req, v, exp);
    endtask

    task automatic fields_chk(input string req, input logic [31:0] st, input logic [31:0] ad,
                              input logic [7:0] sy, input logic ch);
        rd_chk(req, 3'd0, st);
        rd_chk(req, 3'd1, ad);
        rd_chk(req, 3'd2, {24'd0, sy});
        rd_chk(req, 3'd3, {31'd0, ch});
    endtask

    task automatic err(input logic ce, input logic ue, input logic [31:0] a,
                       input logic [7:0] s, input logic c);
        @(negedge clk);
        ce_pulse = ce; ue_pulse = ue; err_addr = a; err_syn = s; err_chan = c;
        @(negedge clk);
        ce_pulse = 1'b0; ue_pulse = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wen = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic t_reset;
        fields_chk("R1", 32'h0, 32'h0, 8'h0, 1'b0);
        rd_chk("R1 cmd", 3'd4, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_ce_fresh;
        err(1'b1, 1'b0, 32'h1234_5678, 8'h3C, 1'b1);
        fields_chk("R2", 32'h1, 32'h1234_5000, 8'h3C, 1'b1);
    endtask

    task automatic t_ce_repeat;
        err(1'b1, 1'b0, 32'hAAAA_A111, 8'h55, 1'b0);
        fields_chk("R5", 32'h1, 32'h1234_5000, 8'h3C, 1'b1);
    endtask

    task automatic t_ue_over_ce;
        err(1'b0, 1'b1, 32'h0F0F_0ABC, 8'hE7, 1'b0);
        fields_chk("R3", 32'h81, 32'h0F0F_0000, 8'hE7, 1'b0);
    endtask

    task automatic t_ue_repeat;
        err(1'b0, 1'b1, 32'h7777_7777, 8'h11, 1'b1);
        fields_chk("R6", 32'h81, 32'h0F0F_0000, 8'hE7, 1'b0);
    endtask

    task automatic t_w1c;
        wr(3'd0, 32'h0000_0001);
        rd_chk("R7 ce only", 3'd0, 32'h80);
        wr(3'd0, 32'hFFFF_FF7E);
        rd_chk("R7 no target bits", 3'd0, 32'h80);
        err(1'b1, 1'b0, 32'h0, 8'h0, 1'b0);
        wr(3'd0, 32'h0000_0080);
        rd_chk("R7 ue only", 3'd0, 32'h01);
        err(1'b0, 1'b1, 32'h0, 8'h0, 1'b0);
        wr(3'd0, 32'h0000_0081);
        rd_chk("R7 both", 3'd0, 32'h0);
    endtask

    task automatic t_ce_under_ue;
        err(1'b0, 1'b1, 32'h2000_0000, 8'h01, 1'b1);
        err(1'b1, 1'b0, 32'h3000_0000, 8'h02, 1'b0);
        fields_chk("R4", 32'h81, 32'h2000_0000, 8'h01, 1'b1);
        wr(3'd0, 32'h81);
    endtask

    task automatic t_same_cycle;
        err(1'b1, 1'b0, 32'h4000_1000, 8'h44, 1'b0);
        @(negedge clk);
        reg_sel = 3'd0; reg_wen = 1'b1; reg_wdata = 32'h1;
        ce_pulse = 1'b1; err_addr = 32'h5000_2FFF; err_syn = 8'h66; err_chan = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; ce_pulse = 1'b0;
        fields_chk("R8", 32'h1, 32'h5000_2000, 8'h66, 1'b1);
        wr(3'd0, 32'h81);
    endtask

    task automatic t_both;
        err(1'b1, 1'b1, 32'h6543_21FF, 8'h99, 1'b1);
        fields_chk("R9", 32'h81, 32'h6543_2000, 8'h99, 1'b1);
        rd_chk("R10 low bits", 3'd1, 32'h6543_2000);
        wr(3'd0, 32'h81);
    endtask

    task automatic t_irq;
        wr(3'd4, 32'h0000_0001);
        rd_chk("R11 cmd readback", 3'd4, 32'h1);
        chk("R11 idle", {31'd0, irq}, 32'h0);
        err(1'b1, 1'b0, 32'h0000_3000, 8'h0A, 1'b0);
        #2 chk("R11 ce enabled", {31'd0, irq}, 32'h1);
        wr(3'd4, 32'h0000_0080);
        #2 chk("R11 ce masked", {31'd0, irq}, 32'h0);
        err(1'b0, 1'b1, 32'h0000_4000, 8'h0B, 1'b0);
        #2 chk("R11 ue enabled", {31'd0, irq}, 32'h1);
        wr(3'd0, 32'h81);
        #2 chk("R11 cleared", {31'd0, irq}, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R11 cmd bits", 3'd4, 32'h81);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_readonly;
        err(1'b1, 1'b0, 32'h0ABC_D123, 8'h5A, 1'b1);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        fields_chk("R12", 32'h1, 32'h0ABC_D000, 8'h5A, 1'b1);
        wr(3'd0, 32'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_ce_fresh;
        t_ce_repeat;
        t_ue_over_ce;
        t_ue_repeat;
        t_w1c;
        t_ce_under_ue;
        t_same_cycle;
        t_both;
        t_irq;
        t_readonly;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule